// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block is the register front end of an embedded flash program/erase engine. A host reaches it over a plain 32-bit memory-mapped bus with a single-cycle write strobe and a combinational read. It holds a key register, a status word, a control word, a target address and a program data word. The control word can only be changed after a correct two-write key sequence. While it is unlocked, software selects one operation (word program, page erase or mass erase) and sets the start bit. The block then sends a one-cycle request to an external array port and holds a busy flag for a fixed, parameterised number of cycles.

When the operation ends, busy and the start bit drop together and an end-of-operation flag is raised. Software clears that flag by writing 1 to it. A key write with any value out of sequence kills the unlock path until the next reset. Software can relock the block at any time by setting the lock bit.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the control word (offset 0x10) reads 0x0000_0080, with only the lock bit 7 set, and the status word (offset 0x0C) reads 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) clears the lock bit.
- R3: A key write that breaks this sequence puts the block in a permanent locked state until reset. This covers a second key first, a repeated first key, or any other value, whether the block was locked or unlocked. In that state the lock bit reads 1 and later correct key pairs leave it at 1.
- R4: While the lock bit is 1, a control write changes nothing except that bit 7 written as 1 keeps it set. Software can never clear the lock bit, and a start request written while locked starts nothing.
- R5: Control bit 0 selects word program, bit 1 page erase, bit 2 mass erase, and bit 6 is start. A start write with exactly one selection bit set raises arr_req_o for one cycle, starting the cycle after the write. arr_op_o is 1 for program, 2 for page erase and 3 for mass erase.
- R6: Status bit 0 (busy) is high for exactly T_PROG, T_PAGE or T_MASS cycles, counted from the cycle after the start write, depending on the operation. Control bit 6 reads 1 for the same cycles and clears together with busy.
- R7: Status bit 5 (end of operation) sets when busy ends. Writing 1 to status bit 5 clears it, and writing 0 leaves it set.
- R8: While busy, writes to the control, address and data registers are ignored, except that setting the lock bit is allowed.
- R9: The address register (offset 0x14) and the data register (offset 0x18) read back what was written. They drive arr_addr_o and arr_data_o, so a page erase targets the page that holds that address.
- R10: A start write with no selection bit, or with more than one, starts nothing: busy stays 0 and no array request is issued.
- R11: Writing 1 to the lock bit while unlocked relocks the block, and a fresh correct key pair unlocks it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| arr_req_o | output | 1 | One-cycle operation request to the array |
| arr_op_o | output | 2 | Operation kind: 1 program, 2 page erase, 3 mass erase |
| arr_addr_o | output | 32 | Target address |
| arr_data_o | output | 32 | Program data word |

## Verification
The hardest state to reach from the ports is the permanent lock, because it can be entered from several different key histories. This includes the unlocked state, where a stray key write must force the lock bit back to 1. The bench resets before each of a sweep of bad key histories, then offers a correct pair and a control write to prove nothing opens. Busy-time checks sweep all three operation kinds. Writes made mid-operation are issued while busy is still high and checked after it falls.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_PAGE = 2'd2,
    OP_MASS = 2'd3
  } op_kind_e;

  localparam logic [7:0] OFS_KEY  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h18;

  localparam logic [DW-1:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [DW-1:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam int unsigned CB_PROG = 0;
  localparam int unsigned CB_PAGE = 1;
  localparam int unsigned CB_MASS = 2;
  localparam int unsigned CB_STRT = 6;
  localparam int unsigned CB_LOCK = 7;
  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_EOP  = 5;
endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
  import flash_pe_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [DW-1:0] key_val_i,
  output logic          unlock_o,
  output logic          kill_o,
  output logic          dead_o
);
  typedef enum logic [1:0] {KS_FIRST, KS_SECOND, KS_DEAD} ks_e;
  ks_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    unlock_o = 1'b0;
    kill_o   = 1'b0;
    if (key_wr_i) begin
      unique case (st_q)
        KS_FIRST:  st_d = (key_val_i == KEY_FIRST) ? KS_SECOND : KS_DEAD;
        KS_SECOND: begin
          if (key_val_i == KEY_SECOND) begin
            st_d     = KS_FIRST;
            unlock_o = 1'b1;
          end else begin
            st_d = KS_DEAD;
          end
        end
        default:   st_d = KS_DEAD;
      endcase
      kill_o = (st_d == KS_DEAD);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_FIRST;
    else         st_q <= st_d;
  end

  assign dead_o = (st_q == KS_DEAD);

  // R3: once dead, stays dead and never unlocks
  a_r3_dead_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);
  a_r3_no_unlock_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !unlock_o);
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_pe_pkg::*;
#(
  parameter int unsigned T_PROG = 4,
  parameter int unsigned T_PAGE = 8,
  parameter int unsigned T_MASS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_kind_e kind_i,
  output logic     busy_o,
  output logic     done_o
);
  localparam int unsigned T_MAX0 = (T_PROG > T_PAGE) ? T_PROG : T_PAGE;
  localparam int unsigned T_MAX  = (T_MAX0 > T_MASS) ? T_MAX0 : T_MASS;
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q, len;
  logic             busy_q;

  always_comb begin
    unique case (kind_i)
      OP_PROG: len = CNT_W'(T_PROG);
      OP_PAGE: len = CNT_W'(T_PAGE);
      default: len = CNT_W'(T_MASS);
    endcase
  end

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len - CNT_W'(1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R8: no new operation while one runs
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R6: completion ends busy
  a_r6_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned T_PROG = 4,
  parameter int unsigned T_PAGE = 8,
  parameter int unsigned T_MASS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              arr_req_o,
  output logic [1:0]        arr_op_o,
  output logic [31:0]       arr_addr_o,
  output logic [31:0]       arr_data_o
);
  logic wr, wr_key, wr_stat, wr_ctrl, wr_addr, wr_data;
  logic unlock, kill, dead;
  logic busy, done, go;
  logic lock_q, pg_q, per_q, mer_q, strt_q, eop_q, arr_req_q;
  logic [31:0] addr_q, data_q;
  op_kind_e kind, arr_op_q;

  assign wr      = req_i && we_i;
  assign wr_key  = wr && (addr_i == ADDR_W'(OFS_KEY));
  assign wr_stat = wr && (addr_i == ADDR_W'(OFS_STAT));
  assign wr_ctrl = wr && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_addr = wr && (addr_i == ADDR_W'(OFS_ADDR));
  assign wr_data = wr && (addr_i == ADDR_W'(OFS_DATA));

  flash_key_seq u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (wr_key),
    .key_val_i (wdata_i),
    .unlock_o  (unlock),
    .kill_o    (kill),
    .dead_o    (dead)
  );

  // exactly one selection bit must accompany start
  always_comb begin
    if (wdata_i[CB_PROG])      kind = OP_PROG;
    else if (wdata_i[CB_PAGE]) kind = OP_PAGE;
    else                       kind = OP_MASS;
  end
  assign go = wr_ctrl && !lock_q && !busy && wdata_i[CB_STRT] &&
              $onehot(wdata_i[CB_MASS:CB_PROG]);

  flash_op_timer #(
    .T_PROG (T_PROG),
    .T_PAGE (T_PAGE),
    .T_MASS (T_MASS)
  ) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go),
    .kind_i  (kind),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b1;
      pg_q      <= 1'b0;
      per_q     <= 1'b0;
      mer_q     <= 1'b0;
      strt_q    <= 1'b0;
      eop_q     <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      arr_req_q <= 1'b0;
      arr_op_q  <= OP_NONE;
    end else begin
      if (unlock) lock_q <= 1'b0;
      if (kill || (wr_ctrl && wdata_i[CB_LOCK])) lock_q <= 1'b1;
      if (wr_ctrl && !lock_q && !busy) begin
        pg_q  <= wdata_i[CB_PROG];
        per_q <= wdata_i[CB_PAGE];
        mer_q <= wdata_i[CB_MASS];
      end
      if (go)        strt_q <= 1'b1;
      else if (done) strt_q <= 1'b0;
      if (done)                          eop_q <= 1'b1;
      else if (wr_stat && wdata_i[SB_EOP]) eop_q <= 1'b0;
      if (wr_addr && !busy) addr_q <= wdata_i;
      if (wr_data && !busy) data_q <= wdata_i;
      arr_req_q <= go;
      if (go) arr_op_q <= kind;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == ADDR_W'(OFS_STAT))
        rdata_o = {26'b0, eop_q, 4'b0, busy};
      else if (addr_i == ADDR_W'(OFS_CTRL))
        rdata_o = {24'b0, lock_q, strt_q, 3'b0, mer_q, per_q, pg_q};
      else if (addr_i == ADDR_W'(OFS_ADDR))
        rdata_o = addr_q;
      else if (addr_i == ADDR_W'(OFS_DATA))
        rdata_o = data_q;
    end
  end

  assign arr_req_o  = arr_req_q;
  assign arr_op_o   = arr_op_q;
  assign arr_addr_o = addr_q;
  assign arr_data_o = data_q;

  // R4: lock only drops on a completed key pair
  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !unlock) |=> lock_q);
  // R3: dead key state keeps the block locked
  a_r3_dead_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead |-> lock_q);
  // R7: end of operation raises the flag
  a_r7_eop_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> eop_q);
  // R6: start bit falls with busy
  a_r6_strt_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !strt_q);
  // R5: array request lasts one cycle
  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_q |=> !arr_req_q);
  // R8: target address frozen during an operation
  a_r8_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(addr_q));
endmodule

// File: tb/sim_flash_pe_ctrl.sv
`timescale 1ns/1ps
module sim_flash_pe_ctrl;
  localparam int T_PROG = 4;
  localparam int T_PAGE = 8;
  localparam int T_MASS = 16;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, arr_addr, arr_data;
  logic arr_req;
  logic [1:0] arr_op;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_pe_ctrl #(.ADDR_W(8), .T_PROG(T_PROG), .T_PAGE(T_PAGE), .T_MASS(T_MASS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .arr_req_o(arr_req), .arr_op_o(arr_op),
    .arr_addr_o(arr_addr), .arr_data_o(arr_data));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic unlock();
    wr(8'h04, K1);
    wr(8'h04, K2);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    rd(8'h10, v); chk("R1 ctrl reset", v, 32'h80);
    rd(8'h0C, v); chk("R1 stat reset", v, 32'h0);

    wr(8'h10, 32'h02); rd(8'h10, v); chk("R4 locked sel ignored", v, 32'h80);
    wr(8'h10, 32'h00); rd(8'h10, v); chk("R4 lock not clearable", v, 32'h80);
    wr(8'h10, 32'h42); chk("R4 locked start no req", {31'b0, arr_req}, 32'h0);
    rd(8'h0C, v); chk("R4 locked start no busy", v, 32'h0);

    unlock(); rd(8'h10, v); chk("R2 unlocked", v, 32'h0);

    wr(8'h14, 32'h0800_1234); rd(8'h14, v); chk("R9 addr readback", v, 32'h0800_1234);
    wr(8'h18, 32'hA5A5_0F0F); rd(8'h18, v); chk("R9 data readback", v, 32'hA5A5_0F0F);

    wr(8'h10, 32'h40); chk("R10 no sel no req", {31'b0, arr_req}, 32'h0);
    rd(8'h0C, v); chk("R10 no sel no busy", v, 32'h0);
    wr(8'h10, 32'h46); chk("R10 two sel no req", {31'b0, arr_req}, 32'h0);
    rd(8'h10, v); chk("R10 two sel ctrl", v, 32'h06);
    wr(8'h10, 32'h00);

    for (int k = 1; k <= 3; k++) begin
      int n, texp;
      texp = (k == 1) ? T_PROG : (k == 2) ? T_PAGE : T_MASS;
      wr(8'h10, (32'h1 << (k - 1)) | 32'h40);
      chk("R5 req", {31'b0, arr_req}, 32'h1);
      chk("R5 op", {30'b0, arr_op}, k);
      chk("R9 arr addr", arr_addr, 32'h0800_1234);
      chk("R9 arr data", arr_data, 32'hA5A5_0F0F);
      rd(8'h10, v); chk("R6 strt set", v, (32'h1 << (k - 1)) | 32'h40);
      n = 0;
      forever begin
        rd(8'h0C, v);
        if (v[0] !== 1'b1) break;
        n++;
        @(posedge clk); #1;
        if (n == 1) chk("R5 req one cycle", {31'b0, arr_req}, 32'h0);
        if (n > 100) break;
      end
      chk("R6 busy cycles", n, texp);
      rd(8'h10, v); chk("R6 strt cleared", v, 32'h1 << (k - 1));
      rd(8'h0C, v); chk("R7 eop set", v, 32'h20);
      wr(8'h0C, 32'h00); rd(8'h0C, v); chk("R7 eop kept on 0", v, 32'h20);
      wr(8'h0C, 32'h20); rd(8'h0C, v); chk("R7 eop cleared", v, 32'h0);
    end

    wr(8'h10, 32'h44);
    wr(8'h14, 32'h0000_0BAD);
    wr(8'h18, 32'h0000_0BAD);
    wr(8'h10, 32'h01);
    rd(8'h0C, v); chk("R8 still busy", v, 32'h1);
    repeat (T_MASS) @(posedge clk);
    #1;
    rd(8'h14, v); chk("R8 addr ignored", v, 32'h0800_1234);
    rd(8'h18, v); chk("R8 data ignored", v, 32'hA5A5_0F0F);
    rd(8'h10, v); chk("R8 ctrl ignored", v, 32'h04);
    wr(8'h0C, 32'h20);
    wr(8'h10, 32'h44);
    wr(8'h10, 32'h80);
    rd(8'h10, v); chk("R8 lock during busy", v, 32'hC4);
    repeat (T_MASS) @(posedge clk);
    #1;

    rd(8'h10, v); chk("R11 relocked", v, 32'h84);
    wr(8'h10, 32'h01); rd(8'h10, v); chk("R11 locked ignore", v, 32'h84);
    unlock(); rd(8'h10, v); chk("R11 reunlocked", v, 32'h04);

    for (int p = 0; p < 5; p++) begin
      do_reset();
      case (p)
        0: wr(8'h04, K2);
        1: begin wr(8'h04, K1); wr(8'h04, K1); end
        2: begin wr(8'h04, K1); wr(8'h04, 32'h0); end
        3: wr(8'h04, 32'hDEAD_BEEF);
        default: begin
          unlock();
          wr(8'h04, 32'h1);
        end
      endcase
      rd(8'h10, v); chk("R3 locked after bad key", v, 32'h80);
      unlock();
      rd(8'h10, v); chk("R3 good keys ignored", v, 32'h80);
      wr(8'h10, 32'h44);
      rd(8'h0C, v); chk("R3 no start when dead", v, 32'h0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule